// File: doc/BRIEF.md
# Task-Event UART Register Front-End

This block is the register side of a UART peripheral that is driven by tasks and reports through events. Software starts and stops the transmitter and the receiver by writing 1 to write-only task words. The hardware then reports what happened by setting event words, which software reads and clears. A word-addressed 32-bit bus with single-cycle access reaches every register. Read data is combinational in the cycle of the request. Writes, and the side effects of reads, take effect at the next rising clock edge. The whole register file stays locked until the magic value 4 is written to the enable word.

Outgoing bytes go to a serializer through a valid/ready byte handshake. Only one byte can be pending at a time. Incoming bytes from a deserializer are stored in a small circular FIFO. Reading the receive-data word removes one byte from that FIFO. A line-break strobe from the receiver sets error flags. One level interrupt combines the four events, each gated by its own mask bit.

Two named state machines control the block. The enable FSM has the states LOCKED and OPEN. It goes from LOCKED to OPEN on a write of 4 to ENABLE. It goes from OPEN to LOCKED on a write of 0, and that transition also stops both directions and raises the timeout event. The transmit FSM has the states TX_IDLE and TX_PEND. It moves to TX_PEND on an accepted TXBYTE write and returns to TX_IDLE when the downstream side completes the handshake.

Top module: `tevt_uart_regs`

Word map (`req_addr`): RXGO 0x00, RXHALT 0x01, TXGO 0x02, TXHALT 0x03, PAUSE 0x04, EV_RXRDY 0x08, EV_TXRDY 0x09, EV_ERR 0x0A, EV_RXTMO 0x0B, IE 0x10, IE_SET 0x11, IE_CLR 0x12, ERRSRC 0x13, ENABLE 0x14, PIN0..PIN3 0x18..0x1B, BAUD 0x1C, RXBYTE 0x1D, TXBYTE 0x1E. Unmapped words and task words read 0, and writes to unmapped words are ignored.

## Requirements
- R1: Writing 4 to ENABLE opens the block, and ENABLE then reads 4. Writing any other nonzero value leaves the enable state as it is. Writing 0 locks the block, clears both started flags and sets EV_RXTMO to 1.
- R2: While the block is locked, every read returns 0 and every write to a word other than ENABLE changes nothing.
- R3: `irq` is high exactly when at least one of these pairs has a nonzero event and a set mask bit: EV_RXRDY with IE bit 0, EV_TXRDY with IE bit 1, EV_ERR with IE bit 2, EV_RXTMO with IE bit 3. It follows every change one edge later.
- R4: A write to IE replaces the mask. A write to IE_SET ORs the written bits into it. A write to IE_CLR clears the written bits. A read of any of the three words returns the current mask.
- R5: Writing exactly 1 to TXGO or RXGO sets the transmit-started or receive-started flag. Any other written value has no effect.
- R6: A TXBYTE write is accepted only when transmit is started and no byte is pending. An accepted byte drives `tx_valid`/`tx_data` from the next cycle and is held until `tx_ready`. The cycle after the handshake, `tx_valid` is low and EV_TXRDY reads 1. Writes made while a byte is pending are dropped.
- R7: TXHALT=1 clears only the transmit-started flag. RXHALT=1 clears the receive-started flag and sets EV_RXTMO to 1. PAUSE=1 does both.
- R8: `rx_ready` is high only while receive is started and the FIFO (6 entries) is not full. A byte presented with `rx_valid` while `rx_ready` is high is stored, and EV_RXRDY becomes 1.
- R9: A RXBYTE read returns the oldest stored byte in bits 7:0. If receive is started and the FIFO is not empty, the read also removes that byte and sets EV_RXRDY to 1 when bytes remain. Otherwise the FIFO is left unchanged.
- R10: A write to ERRSRC clears each bit that is written as 1. A one-cycle `line_break` pulse sets ERRSRC bits 1:0 and sets EV_ERR to 1.
- R11: After reset, PIN0..PIN3 read 0xFFFFFFFF and BAUD reads 0x04000000. The mask, the events, ERRSRC, the FIFO, both started flags and the enable state are all cleared, and `irq`, `tx_valid` and `rx_ready` are low.
- R12: EV_RXRDY changes on a bus write only when the written value is 0, which clears it. EV_TXRDY, EV_ERR and EV_RXTMO take the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word index |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational in the request cycle |
| tx_valid | output | 1 | Pending transmit byte is offered |
| tx_data | output | 8 | Pending transmit byte |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_data | input | 8 | Offered receive byte |
| rx_ready | output | 1 | FIFO accepts a byte |
| line_break | input | 1 | Break condition strobe |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due in the same cycle as the request, so the bench samples `rd_data` 1 ns after it drives the address. Every register write, task, push, pop and handshake shows its effect one edge later. `tx_valid` rises the cycle after an accepted TXBYTE write, and EV_TXRDY and `irq` change the cycle after the handshake or event. For that reason every check is placed at least one full cycle after the stimulus edge, and inputs change 1 ns after a rising edge. The FIFO is filled from a non-zero head so that both its full condition and its wrap-around are checked.

// File: rtl/tevt_uart_pkg.sv
package tevt_uart_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int N_PIN   = 4;
    localparam int N_EVT   = 4;

    localparam logic [ADDR_W-1:0] A_RXGO    = 5'h00;
    localparam logic [ADDR_W-1:0] A_RXHALT  = 5'h01;
    localparam logic [ADDR_W-1:0] A_TXGO    = 5'h02;
    localparam logic [ADDR_W-1:0] A_TXHALT  = 5'h03;
    localparam logic [ADDR_W-1:0] A_PAUSE   = 5'h04;
    localparam logic [ADDR_W-1:0] A_EV_RX   = 5'h08;
    localparam logic [ADDR_W-1:0] A_EV_TX   = 5'h09;
    localparam logic [ADDR_W-1:0] A_EV_ERR  = 5'h0A;
    localparam logic [ADDR_W-1:0] A_EV_TMO  = 5'h0B;
    localparam logic [ADDR_W-1:0] A_IE      = 5'h10;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 5'h11;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 5'h12;
    localparam logic [ADDR_W-1:0] A_ERRSRC  = 5'h13;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 5'h14;
    localparam logic [ADDR_W-1:0] A_PIN0    = 5'h18;
    localparam logic [ADDR_W-1:0] A_BAUD    = 5'h1C;
    localparam logic [ADDR_W-1:0] A_RXBYTE  = 5'h1D;
    localparam logic [ADDR_W-1:0] A_TXBYTE  = 5'h1E;

    localparam logic [DATA_W-1:0] UNLOCK_CODE = 32'd4;
    localparam logic [DATA_W-1:0] PIN_RST     = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] BAUD_RST    = 32'h0400_0000;

    typedef enum logic [0:0] {EN_LOCKED = 1'b0, EN_OPEN = 1'b1} en_state_t;
    typedef enum logic [0:0] {TX_IDLE = 1'b0, TX_PEND = 1'b1} tx_state_t;
endpackage

// File: rtl/tevt_rx_fifo.sv
module tevt_rx_fifo #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] fill,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W:0]   tail_sum;
    logic [PTR_W-1:0] tail;

    always_comb begin
        tail_sum = {1'b0, head_q} + (PTR_W+1)'(cnt_q);
        if (tail_sum >= (PTR_W+1)'(DEPTH)) tail_sum = tail_sum - (PTR_W+1)'(DEPTH);
        tail = tail_sum[PTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) mem[tail] <= push_data;
            if (pop) head_q <= (head_q == PTR_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign head_data = mem[head_q];
    assign fill      = cnt_q;
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);
endmodule

// File: rtl/tevt_tx_fsm.sv
module tevt_tx_fsm
    import tevt_uart_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [WIDTH-1:0] tx_data,
    output logic             idle,
    output logic             done
);
    tx_state_t        state_q, state_d;
    logic [WIDTH-1:0] byte_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load)     state_d = TX_PEND;
            TX_PEND: if (tx_ready) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load && state_q == TX_IDLE) byte_q <= load_data;
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        idle     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            TX_IDLE: idle = 1'b1;
            TX_PEND: begin
                tx_valid = 1'b1;
                done     = tx_ready;
            end
        endcase
    end

    assign tx_data = byte_q;
endmodule

// File: rtl/tevt_irq_comb.sv
module tevt_irq_comb #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] ev_nz,
    input  logic [N_SRC-1:0] mask,
    output logic             irq
);
    logic [N_SRC-1:0] hit;
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = ev_nz[g] & mask[g];
    end
    assign irq = |hit;
endmodule

// File: rtl/tevt_uart_regs.sv
module tevt_uart_regs
    import tevt_uart_pkg::*;
#(
    parameter int FIFO_DEPTH = 6,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              line_break,
    output logic              irq
);
    en_state_t         en_q;
    logic              tx_go_q, rx_go_q;
    logic [DATA_W-1:0] ev_rx_q, ev_tx_q, ev_err_q, ev_tmo_q;
    logic [DATA_W-1:0] ie_q, errsrc_q, baud_q;
    logic [DATA_W-1:0] pin_q [N_PIN];

    logic              is_open, wr, rd, wr_ok, pop, push, tx_load;
    logic              tx_idle, tx_done, fifo_full, fifo_empty;
    logic [BYTE_W-1:0] head_byte;
    logic [CNT_W-1:0]  rx_fill;
    logic [N_EVT-1:0]  ev_nz;

    assign is_open = (en_q == EN_OPEN);
    assign wr      = req_valid & req_write;
    assign rd      = req_valid & ~req_write;
    assign wr_ok   = wr & is_open;
    assign rx_ready = rx_go_q & ~fifo_full;
    assign push    = rx_valid & rx_ready;
    assign pop     = rd & is_open & (req_addr == A_RXBYTE) & rx_go_q & ~fifo_empty;
    assign tx_load = wr_ok & (req_addr == A_TXBYTE) & tx_go_q & tx_idle;
    assign ev_nz   = {ev_tmo_q != '0, ev_err_q != '0, ev_tx_q != '0, ev_rx_q != '0};

    tevt_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_data), .pop(pop),
        .head_data(head_byte), .fill(rx_fill), .full(fifo_full), .empty(fifo_empty)
    );

    tevt_tx_fsm #(.WIDTH(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(req_wdata[BYTE_W-1:0]),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .idle(tx_idle), .done(tx_done)
    );

    tevt_irq_comb #(.N_SRC(N_EVT)) u_irq (
        .ev_nz(ev_nz), .mask(ie_q[N_EVT-1:0]), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= EN_LOCKED;
            tx_go_q  <= 1'b0;
            rx_go_q  <= 1'b0;
            ev_rx_q  <= '0;
            ev_tx_q  <= '0;
            ev_err_q <= '0;
            ev_tmo_q <= '0;
            ie_q     <= '0;
            errsrc_q <= '0;
            baud_q   <= BAUD_RST;
            for (int i = 0; i < N_PIN; i++) pin_q[i] <= PIN_RST;
        end else begin
            if (wr && req_addr == A_ENABLE) begin
                unique case (en_q)
                    EN_LOCKED: if (req_wdata == UNLOCK_CODE) en_q <= EN_OPEN;
                    EN_OPEN: if (req_wdata == '0) begin
                        en_q     <= EN_LOCKED;
                        tx_go_q  <= 1'b0;
                        rx_go_q  <= 1'b0;
                        ev_tmo_q <= 32'd1;
                    end
                endcase
                if (en_q == EN_LOCKED && req_wdata == '0) begin
                    tx_go_q  <= 1'b0;
                    rx_go_q  <= 1'b0;
                    ev_tmo_q <= 32'd1;
                end
            end else if (wr_ok) begin
                case (req_addr)
                    A_RXGO:   if (req_wdata == 32'd1) rx_go_q <= 1'b1;
                    A_TXGO:   if (req_wdata == 32'd1) tx_go_q <= 1'b1;
                    A_TXHALT: if (req_wdata == 32'd1) tx_go_q <= 1'b0;
                    A_RXHALT: if (req_wdata == 32'd1) begin
                        rx_go_q  <= 1'b0;
                        ev_tmo_q <= 32'd1;
                    end
                    A_PAUSE:  if (req_wdata == 32'd1) begin
                        tx_go_q  <= 1'b0;
                        rx_go_q  <= 1'b0;
                        ev_tmo_q <= 32'd1;
                    end
                    A_EV_RX:  if (req_wdata == '0) ev_rx_q <= '0;
                    A_EV_TX:  ev_tx_q  <= req_wdata;
                    A_EV_ERR: ev_err_q <= req_wdata;
                    A_EV_TMO: ev_tmo_q <= req_wdata;
                    A_IE:     ie_q <= req_wdata;
                    A_IE_SET: ie_q <= ie_q | req_wdata;
                    A_IE_CLR: ie_q <= ie_q & ~req_wdata;
                    A_ERRSRC: errsrc_q <= errsrc_q & ~req_wdata;
                    A_BAUD:   baud_q <= req_wdata;
                    default: begin
                        for (int i = 0; i < N_PIN; i++)
                            if (req_addr == A_PIN0 + ADDR_W'(i)) pin_q[i] <= req_wdata;
                    end
                endcase
            end
            if ((pop && rx_fill > CNT_W'(1)) || push) ev_rx_q <= 32'd1;
            if (tx_done) ev_tx_q <= 32'd1;
            if (line_break) begin
                errsrc_q <= errsrc_q | 32'd3;
                ev_err_q <= 32'd1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd && is_open) begin
            case (req_addr)
                A_EV_RX:  rd_data = ev_rx_q;
                A_EV_TX:  rd_data = ev_tx_q;
                A_EV_ERR: rd_data = ev_err_q;
                A_EV_TMO: rd_data = ev_tmo_q;
                A_IE, A_IE_SET, A_IE_CLR: rd_data = ie_q;
                A_ERRSRC: rd_data = errsrc_q;
                A_ENABLE: rd_data = UNLOCK_CODE;
                A_BAUD:   rd_data = baud_q;
                A_RXBYTE: rd_data = DATA_W'(head_byte);
                A_TXBYTE: rd_data = DATA_W'(tx_data);
                default: begin
                    for (int i = 0; i < N_PIN; i++)
                        if (req_addr == A_PIN0 + ADDR_W'(i)) rd_data = pin_q[i];
                end
            endcase
        end
    end
endmodule

// File: rtl/tevt_uart_regs_chk.sv
module tevt_uart_regs_chk
    import tevt_uart_pkg::*;
#(
    parameter int FIFO_DEPTH = 6,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              is_open,
    input logic [N_EVT-1:0]  ev_nz,
    input logic [DATA_W-1:0] ie_q,
    input logic              irq,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] tx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [CNT_W-1:0]  rx_fill
);
    // R1: a write of 0 to ENABLE locks the block and raises the timeout event
    p_lock_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == A_ENABLE && req_wdata == '0)
        |=> (!is_open && ev_nz[3]));

    // R2: locked reads return zero
    p_locked_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && req_valid && !req_write) |-> (rd_data == '0));

    // R3: no interrupt while all four source masks are clear
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q[N_EVT-1:0] == '0) |-> !irq);

    // R6: an offered byte stays put until taken
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6: handshake raises the transmit-ready event
    p_tx_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (ev_nz[1] && !tx_valid));

    // R8: FIFO never exceeds its depth and refuses bytes when full
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill == CNT_W'(FIFO_DEPTH)) |-> !rx_ready);

    // R8: a stored byte raises the receive-ready event
    p_rx_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> ev_nz[0]);
endmodule

bind tevt_uart_regs tevt_uart_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .is_open(is_open), .ev_nz(ev_nz), .ie_q(ie_q), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_fill(rx_fill)
);

// File: tb/tevt_uart_regs_bench.sv
module tevt_uart_regs_bench;
    localparam logic [4:0] RXGO = 5'h00, RXHALT = 5'h01, TXGO = 5'h02, TXHALT = 5'h03,
                           PAUSE = 5'h04, EVRX = 5'h08, EVTX = 5'h09, EVERR = 5'h0A,
                           EVTMO = 5'h0B, IE = 5'h10, IESET = 5'h11, IECLR = 5'h12,
                           ERRSRC = 5'h13, ENA = 5'h14, PIN0 = 5'h18, BAUD = 5'h1C,
                           RXBYTE = 5'h1D, TXBYTE = 5'h1E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, line_break = 1'b0, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tevt_uart_regs u_tevt_uart_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .line_break(line_break), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // all tasks start and end 1 ns after a rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 d = rd_data;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 irq after reset", {31'd0, irq}, 0);
        chk("R11 tx_valid after reset", {31'd0, tx_valid}, 0);
        chk("R11 rx_ready after reset", {31'd0, rx_ready}, 0);
        wr(ENA, 32'd5);
        rd_chk("R1 value 5 keeps lock", BAUD, 0);
        wr(ENA, 32'd4);
        rd_chk("R1 enable reads 4", ENA, 32'd4);
        rd_chk("R11 baud reset", BAUD, 32'h0400_0000);
        for (int i = 0; i < 4; i++)
            rd_chk("R11 pin reset", PIN0 + 5'(i), 32'hFFFF_FFFF);
        rd_chk("R11 mask reset", IE, 0);
        rd_chk("R11 errsrc reset", ERRSRC, 0);
        rd_chk("R11 rx event reset", EVRX, 0);
        rd_chk("R11 timeout event reset", EVTMO, 0);
    endtask

    task automatic t_locked;
        wr(RXGO, 32'd1);
        wr(ENA, 32'd0);
        chk("R1 lock stops receive", {31'd0, rx_ready}, 0);
        rd_chk("R2 locked read zero", BAUD, 0);
        wr(IE, 32'hF);
        wr(BAUD, 32'h1234);
        wr(ENA, 32'd4);
        rd_chk("R2 locked write ignored (mask)", IE, 0);
        rd_chk("R2 locked write ignored (baud)", BAUD, 32'h0400_0000);
        rd_chk("R1 lock raised timeout", EVTMO, 32'd1);
        wr(EVTMO, 32'd0);
    endtask

    task automatic t_mask;
        wr(IE, 32'h5);
        rd_chk("R4 direct write", IE, 32'h5);
        wr(IESET, 32'h2);
        rd_chk("R4 set alias", IESET, 32'h7);
        wr(IECLR, 32'h4);
        rd_chk("R4 clear alias", IECLR, 32'h3);
    endtask

    task automatic t_tx;
        wr(TXGO, 32'd2);
        wr(TXBYTE, 32'hA5);
        chk("R5 value 2 does not start", {31'd0, tx_valid}, 0);
        wr(TXGO, 32'd1);
        wr(TXBYTE, 32'hA5);
        chk("R6 byte offered", {23'd0, tx_valid, tx_data}, {23'd1, 8'hA5});
        wr(TXBYTE, 32'h3C);
        chk("R6 pending byte kept", {23'd0, tx_valid, tx_data}, {23'd1, 8'hA5});
        tx_ready = 1'b1;
        @(posedge clk); #1;
        tx_ready = 1'b0;
        chk("R6 valid drops after handshake", {31'd0, tx_valid}, 0);
        chk("R3 irq from tx event", {31'd0, irq}, 1);
        rd_chk("R6 tx event set", EVTX, 32'd1);
        wr(EVTX, 32'd0);
        chk("R3 irq clears", {31'd0, irq}, 0);
        wr(RXGO, 32'd1);
        wr(TXHALT, 32'd1);
        wr(TXBYTE, 32'h55);
        chk("R7 halted tx refuses byte", {31'd0, tx_valid}, 0);
        chk("R7 tx halt leaves rx", {31'd0, rx_ready}, 1);
        rd_chk("R7 tx halt no timeout", EVTMO, 0);
        wr(TXGO, 32'd1);
        wr(PAUSE, 32'd1);
        chk("R7 pause stops rx", {31'd0, rx_ready}, 0);
        wr(TXBYTE, 32'h55);
        chk("R7 pause stops tx", {31'd0, tx_valid}, 0);
        rd_chk("R7 pause timeout", EVTMO, 32'd1);
        wr(EVTMO, 32'd0);
    endtask

    task automatic t_rx;
        wr(IE, 32'd0);
        wr(RXGO, 32'd1);
        push(8'h11);
        push(8'h22);
        rd_chk("R8 rx event set", EVRX, 32'd1);
        wr(EVRX, 32'd5);
        rd_chk("R12 nonzero write keeps rx event", EVRX, 32'd1);
        wr(EVRX, 32'd0);
        rd_chk("R12 zero clears rx event", EVRX, 0);
        rd_chk("R9 first byte", RXBYTE, 32'h11);
        rd_chk("R9 event re-raised", EVRX, 32'd1);
        wr(EVRX, 32'd0);
        rd_chk("R9 second byte", RXBYTE, 32'h22);
        rd_chk("R9 no re-raise when empty", EVRX, 0);
        for (int i = 0; i < 6; i++) push(8'h40 + 8'(i));
        chk("R8 full refuses", {31'd0, rx_ready}, 0);
        for (int i = 0; i < 6; i++)
            rd_chk("R9 wrapped order", RXBYTE, 32'h40 + 32'(i));
        chk("R8 space again", {31'd0, rx_ready}, 1);
        push(8'h77);
        wr(RXHALT, 32'd1);
        rd_chk("R7 rx halt timeout", EVTMO, 32'd1);
        rd_chk("R9 halted read", RXBYTE, 32'h77);
        rd_chk("R9 halted read no pop", RXBYTE, 32'h77);
        wr(RXGO, 32'd1);
        rd_chk("R9 pop after restart", RXBYTE, 32'h77);
        chk("R8 rx_ready with space", {31'd0, rx_ready}, 1);
        wr(EVTMO, 32'd0);
        wr(EVRX, 32'd0);
    endtask

    task automatic t_err;
        wr(IE, 32'h4);
        chk("R3 irq idle", {31'd0, irq}, 0);
        line_break = 1'b1;
        @(posedge clk); #1;
        line_break = 1'b0;
        chk("R3 irq from error", {31'd0, irq}, 1);
        rd_chk("R10 break sets source bits", ERRSRC, 32'd3);
        rd_chk("R10 break sets error event", EVERR, 32'd1);
        wr(ERRSRC, 32'd1);
        rd_chk("R10 write-one clears", ERRSRC, 32'd2);
        wr(EVERR, 32'd7);
        rd_chk("R12 error event takes value", EVERR, 32'd7);
        wr(EVERR, 32'd0);
        chk("R3 irq after clear", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_locked();
        t_mask();
        t_tx();
        t_rx();
        t_err();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule